// File: doc/BRIEF.md
# Translation Cycle Response Checker

This block decides how a translated logical bus cycle ends once the address translation cache lookup has produced its result. At the start of each logical cycle it weighs the lookup status against the cycle's direction, the read-modify-write indicator and an access-level violation flag. It then answers with one of three endings. A clean cycle raises nothing. An abort raises bus error alone. A relinquish-and-retry raises bus error and halt together, so that the bus master backs off while the descriptor is fetched or updated.

It also produces two side signals. The first is a cache load inhibit that marks the cycle's data, or table-walk traffic, as non-cacheable. The second is a hold that keeps physical-bus arbitration frozen for the length of a locked read-modify-write sequence. The response is captured on the first clock of a cycle and held until the logical address strobe drops.

Top module: `xlat_resp_ctl`

## Requirements
- R1: After reset, and whenever no cycle is active, berr_o, halt_o and cli_o are low; halt_o is never high without berr_o.
- R2: A cycle whose lookup misses (hit_i low) ends in retry: berr_o and halt_o both high, whatever the other status bits.
- R3: A hit whose effective access is a write (rd_i low, or rmc_i high) to a page with mod_i low ends in retry. This takes priority over the entry's bus-error bit and over write protection.
- R4: A hit with berr_bit_i high that does not fall under R3 ends in abort: berr_o high, halt_o low. This takes priority over write protection and the level violation.
- R5: A write (rd_i low) to a page with wp_i high ends in abort. A plain read of the same page ends cleanly.
- R6: A read with rmc_i high is judged as a write. If wp_i is high it aborts, and if mod_i is low it retries.
- R7: An access-level violation (lvl_viol_i high) on an otherwise clean hit ends in abort. It has the lowest priority of all causes.
- R8: The response is decided from the inputs on the first clock where las_i is high, appears on the next clock, and stays constant while las_i stays high. It clears on the clock after las_i goes low.
- R9: A hit with ci_i high raises cli_o for the cycle with the same timing as R8, whether or not this unit owns the physical bus. ci_i is ignored on a miss.
- R10: With cfg_walk_cli_i high during reset, cli_o follows walk_i one clock late. With it low during reset, walk_i has no effect on cli_o.
- R11: arb_hold_o rises the clock after rmc_i and phys_start_i are both high. It stays high while rmc_i stays high and falls the clock after rmc_i drops. phys_start_i alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_walk_cli_i | input | 1 | Captured while in reset: enables inhibit during table walks |
| las_i | input | 1 | Logical address strobe, high while the cycle is active |
| rd_i | input | 1 | Cycle direction, 1 = read, 0 = write |
| rmc_i | input | 1 | Read-modify-write lock indicator |
| hit_i | input | 1 | Lookup found a mapping |
| wp_i | input | 1 | Matched entry is write-protected |
| berr_bit_i | input | 1 | Matched entry carries a bus-error mark |
| mod_i | input | 1 | Matched entry's page already modified |
| ci_i | input | 1 | Matched entry is cache-inhibited |
| lvl_viol_i | input | 1 | Access-level protection violation |
| walk_i | input | 1 | Table search in progress |
| phys_start_i | input | 1 | Physical cycle for the translation has started |
| berr_o | output | 1 | Bus error to the logical master |
| halt_o | output | 1 | Halt, paired with berr_o for retry |
| cli_o | output | 1 | Cache load inhibit |
| arb_hold_o | output | 1 | Physical-bus arbitration suspended |

## Verification
Cache load inhibit has two sources: the entry's inhibit bit, held for a cycle, and the table-walk term, which follows walk_i. Both can be active on the same clock. The bench starts a walk inside a cache-inhibited cycle and ends it while the cycle still runs. It then starts a walk again after the strobe drops, and expects cli_o to stay high exactly while either source holds. A second overlap, an abort landing while an arbitration hold is active, is also provoked. The bench checks that each output follows its own rule on every clock.

// File: rtl/xlat_resp_pkg.sv
package xlat_resp_pkg;
  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_ABORT = 2'd1,
    RESP_RETRY = 2'd2
  } resp_e;

  typedef struct packed {
    logic hit;
    logic wp;
    logic berr;
    logic mod;
    logic ci;
  } atc_res_t;
endpackage

// File: rtl/xlat_resp_eval.sv
module xlat_resp_eval
  import xlat_resp_pkg::*;
(
  input  atc_res_t res_i,
  input  logic     rd_i,
  input  logic     rmc_i,
  input  logic     lvl_viol_i,
  output resp_e    resp_o
);
  logic eff_wr;
  assign eff_wr = !rd_i || rmc_i;

  always_comb begin
    if (!res_i.hit || (eff_wr && !res_i.mod)) resp_o = RESP_RETRY;
    else if (res_i.berr)                      resp_o = RESP_ABORT;
    else if (res_i.wp && eff_wr)              resp_o = RESP_ABORT;
    else if (lvl_viol_i)                      resp_o = RESP_ABORT;
    else                                      resp_o = RESP_NONE;
  end
endmodule

// File: rtl/xlat_resp_hold.sv
module xlat_resp_hold
  import xlat_resp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  las_i,
  input  resp_e resp_i,
  input  logic  ci_i,
  output logic  berr_o,
  output logic  halt_o,
  output logic  ci_o
);
  logic  act_q;
  resp_e resp_q;
  logic  ci_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      resp_q <= RESP_NONE;
      ci_q   <= 1'b0;
    end else if (!las_i) begin
      act_q  <= 1'b0;
      resp_q <= RESP_NONE;
      ci_q   <= 1'b0;
    end else if (!act_q) begin
      act_q  <= 1'b1;
      resp_q <= resp_i;
      ci_q   <= ci_i;
    end
  end

  assign berr_o = (resp_q != RESP_NONE);
  assign halt_o = (resp_q == RESP_RETRY);
  assign ci_o   = ci_q;
endmodule

// File: rtl/xlat_cli_gen.sv
module xlat_cli_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_i,
  input  logic walk_i,
  input  logic entry_ci_i,
  output logic cli_o
);
  logic cfg_q;
  logic walk_q;

  // configuration sampled only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) cfg_q <= cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) walk_q <= 1'b0;
    else         walk_q <= walk_i && cfg_q;
  end

  assign cli_o = walk_q || entry_ci_i;
endmodule

// File: rtl/xlat_arb_lock.sv
module xlat_arb_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rmc_i,
  input  logic phys_start_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= 1'b0;
    else if (hold_q) hold_q <= rmc_i;
    else             hold_q <= rmc_i && phys_start_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/xlat_resp_ctl.sv
module xlat_resp_ctl
  import xlat_resp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_walk_cli_i,
  input  logic las_i,
  input  logic rd_i,
  input  logic rmc_i,
  input  logic hit_i,
  input  logic wp_i,
  input  logic berr_bit_i,
  input  logic mod_i,
  input  logic ci_i,
  input  logic lvl_viol_i,
  input  logic walk_i,
  input  logic phys_start_i,
  output logic berr_o,
  output logic halt_o,
  output logic cli_o,
  output logic arb_hold_o
);
  atc_res_t res;
  resp_e    resp;
  logic     entry_ci;

  assign res = '{hit: hit_i, wp: wp_i, berr: berr_bit_i, mod: mod_i, ci: ci_i};

  xlat_resp_eval u_eval (
    .res_i      (res),
    .rd_i       (rd_i),
    .rmc_i      (rmc_i),
    .lvl_viol_i (lvl_viol_i),
    .resp_o     (resp)
  );

  xlat_resp_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .las_i  (las_i),
    .resp_i (resp),
    .ci_i   (res.hit && res.ci),
    .berr_o (berr_o),
    .halt_o (halt_o),
    .ci_o   (entry_ci)
  );

  xlat_cli_gen u_cli (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg_walk_cli_i),
    .walk_i     (walk_i),
    .entry_ci_i (entry_ci),
    .cli_o      (cli_o)
  );

  xlat_arb_lock u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rmc_i        (rmc_i),
    .phys_start_i (phys_start_i),
    .hold_o       (arb_hold_o)
  );
endmodule

// File: rtl/xlat_resp_ctl_chk.sv
module xlat_resp_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic las_i,
  input logic rd_i,
  input logic rmc_i,
  input logic hit_i,
  input logic wp_i,
  input logic berr_bit_i,
  input logic mod_i,
  input logic phys_start_i,
  input logic berr_o,
  input logic halt_o,
  input logic arb_hold_o
);
  a_r1_halt_needs_berr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> berr_o);

  a_r2_miss_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (las_i && !$past(las_i) && !hit_i) |=> (berr_o && halt_o));

  a_r5_wp_write_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (las_i && !$past(las_i) && hit_i && mod_i && !berr_bit_i && wp_i && !rd_i)
      |=> (berr_o && !halt_o));

  a_r6_rmc_wp_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (las_i && !$past(las_i) && hit_i && mod_i && !berr_bit_i && wp_i && rd_i && rmc_i)
      |=> (berr_o && !halt_o));

  a_r8_resp_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (las_i && $past(las_i)) |=> ($stable(berr_o) && $stable(halt_o)));

  a_r8_resp_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !las_i |=> (!berr_o && !halt_o));

  a_r11_hold_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmc_i && phys_start_i) |=> arb_hold_o);

  a_r11_hold_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rmc_i |=> !arb_hold_o);
endmodule

bind xlat_resp_ctl xlat_resp_ctl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .las_i        (las_i),
  .rd_i         (rd_i),
  .rmc_i        (rmc_i),
  .hit_i        (hit_i),
  .wp_i         (wp_i),
  .berr_bit_i   (berr_bit_i),
  .mod_i        (mod_i),
  .phys_start_i (phys_start_i),
  .berr_o       (berr_o),
  .halt_o       (halt_o),
  .arb_hold_o   (arb_hold_o)
);

// File: tb/xlat_resp_ctl_bench.sv
`timescale 1ns/1ps
module xlat_resp_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg = 1'b1;
  logic las = 0, rd = 1, rmc = 0, hit = 1, wp = 0, bb = 0, md = 1, ci = 0, lvl = 0;
  logic walk = 0, pstart = 0;
  logic berr, halt, cli, arb;

  int vectors = 0;
  int miscmp  = 0;
  string req  = "R1";

  always #2.5 clk = ~clk;

  xlat_resp_ctl u_xlat_resp_ctl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_walk_cli_i(cfg), .las_i(las), .rd_i(rd),
    .rmc_i(rmc), .hit_i(hit), .wp_i(wp), .berr_bit_i(bb), .mod_i(md), .ci_i(ci),
    .lvl_viol_i(lvl), .walk_i(walk), .phys_start_i(pstart),
    .berr_o(berr), .halt_o(halt), .cli_o(cli), .arb_hold_o(arb)
  );

  // behavioural reference: 0 none, 1 abort, 2 retry
  int  m_resp = 0;
  bit  m_act = 0, m_ci = 0, m_walk = 0, m_arb = 0, m_cfg = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_resp = 0; m_act = 0; m_ci = 0; m_walk = 0; m_arb = 0;
      if (clk) m_cfg = cfg;
    end else begin
      bit w;
      w = (rd == 1'b0) || (rmc == 1'b1);
      if (!las) begin
        m_resp = 0; m_act = 0; m_ci = 0;
      end else if (!m_act) begin
        m_act = 1;
        m_ci  = hit && ci;
        if (!hit)          m_resp = 2;
        else if (w && !md) m_resp = 2;
        else if (bb)       m_resp = 1;
        else if (wp && w)  m_resp = 1;
        else if (lvl)      m_resp = 1;
        else               m_resp = 0;
      end
      m_walk = walk && m_cfg;
      m_arb  = m_arb ? rmc : (rmc && pstart);
    end
  end

  task automatic cmp(string nm, logic got, bit exp);
    if (got !== exp) begin
      miscmp++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, nm, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    cmp("berr_o", berr, m_resp != 0);
    cmp("halt_o", halt, m_resp == 2);
    cmp("cli_o", cli, m_ci || m_walk);
    cmp("arb_hold_o", arb, m_arb);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // one logical cycle: strobe held for n clocks then released
  task automatic xact(string r, bit r_rd, bit r_rmc, bit r_hit, bit r_wp, bit r_bb,
                      bit r_md, bit r_ci, bit r_lvl, int n);
    @(negedge clk);
    req = r;
    rd = r_rd; rmc = r_rmc; hit = r_hit; wp = r_wp; bb = r_bb; md = r_md;
    ci = r_ci; lvl = r_lvl; las = 1;
    repeat (n) @(negedge clk);
    las = 0; rmc = 0;
    idle(1);
  endtask

  initial begin
    fork
      begin
        #200000;
        miscmp++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
      end
    join_none

    req = "R1"; cfg = 1;
    idle(4);
    rst_n = 1;
    idle(3);

    // R2 miss retries regardless of other bits
    xact("R2", 1, 0, 0, 1, 1, 0, 1, 1, 3);
    xact("R2", 0, 0, 0, 0, 0, 1, 0, 0, 2);
    // R3 unmodified write retries ahead of bus-error bit and protection
    xact("R3", 0, 0, 1, 1, 1, 0, 0, 0, 3);
    xact("R3", 1, 0, 1, 0, 0, 0, 0, 0, 2); // plain read unmodified: clean
    // R4 entry bus-error bit over protection and level
    xact("R4", 0, 0, 1, 1, 1, 1, 0, 1, 3);
    xact("R4", 1, 0, 1, 0, 1, 1, 0, 0, 2);
    // R5 protected write aborts, protected read clean
    xact("R5", 0, 0, 1, 1, 0, 1, 0, 0, 3);
    xact("R5", 1, 0, 1, 1, 0, 1, 0, 0, 3);
    // R6 locked read judged as write
    xact("R6", 1, 1, 1, 1, 0, 1, 0, 0, 3);
    xact("R6", 1, 1, 1, 0, 0, 0, 0, 0, 3);
    // R7 level violation lowest priority
    xact("R7", 1, 0, 1, 0, 0, 1, 0, 1, 3);
    xact("R7", 0, 0, 1, 0, 0, 0, 0, 1, 2);

    // R8 inputs change mid-cycle, response must not follow
    @(negedge clk);
    req = "R8"; rd = 1; rmc = 0; hit = 1; wp = 0; bb = 0; md = 1; ci = 0; lvl = 0; las = 1;
    idle(2);
    hit = 0; bb = 1; lvl = 1;
    idle(3);
    las = 0; hit = 1; bb = 0; lvl = 0;
    idle(2);
    xact("R8", 1, 0, 0, 0, 0, 1, 0, 0, 1); // single-clock strobe

    // R9 entry inhibit, ignored on miss
    xact("R9", 1, 0, 1, 0, 0, 1, 1, 0, 4);
    xact("R9", 1, 0, 0, 0, 0, 1, 1, 0, 3);

    // R10 walk inhibit enabled; overlap with entry inhibit
    req = "R10";
    @(negedge clk); walk = 1;
    idle(3);
    @(negedge clk);
    req = "R10"; rd = 1; hit = 1; md = 1; ci = 1; las = 1;
    idle(2); walk = 0;
    idle(2); las = 0; ci = 0;
    walk = 1; idle(2); walk = 0; idle(2);

    // R11 arbitration hold; overlaps an abort
    req = "R11";
    @(negedge clk); pstart = 1; idle(2); pstart = 0; idle(1);
    @(negedge clk);
    rmc = 1; rd = 1; hit = 1; wp = 1; md = 1; bb = 0; lvl = 0; las = 1;
    idle(1); pstart = 1; idle(1); pstart = 0;
    idle(3); las = 0;
    idle(2); rmc = 0;
    idle(3);

    // R10 second reset with walk inhibit disabled
    req = "R10";
    @(negedge clk); rst_n = 0; cfg = 0;
    idle(3); rst_n = 1; cfg = 1;
    idle(1); walk = 1; idle(4); walk = 0; idle(2);
    req = "R1";
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule